// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block is a byte-wide timer on a host bus. It holds three independent 16-bit down-counters. Each counter has its own gate input and output pin. The block takes four consecutive port addresses: one data port per counter and one shared control port. The host writes a control word to the control port to choose a counter and set two things for it: how its 16-bit value is split across 8-bit transfers, and which counting mode it runs. The host then writes the reload value through that counter's data port.

All counters step on a common count-enable tick. A counter moves only while its gate is high and after a complete reload value has arrived. Two modes actually count. The rate generator gives a one-tick low pulse every N ticks. The square wave mode inverts its output at every reload, so the period is 2N ticks. The other mode codes are stored but do not make the counter move.

A data-port read returns a byte of the counter's current value. When the access mode uses both bytes, a per-channel byte-order flag decides which byte comes out. That same flag also steps the two-byte write sequence.

Top module: `pit3_timer`

## Requirements
- R1: Port offset 0, 1 and 2 are the data ports of counters 0, 1 and 2. Offset 3 is the control port. A read of offset 3 returns 0xFF.
- R2: Control word bits 7:6 pick the target counter: 00, 01 or 10. The code 11 changes no counter's settings, value or output.
- R3: A control-word write clears the target counter's byte-order flag and its loaded flag. It also forces that counter's output high. An unloaded counter holds its value, and its next data write is taken as the low byte.
- R4: When access bits 5:4 are 10 (low byte only), a data write loads {0x00, data}, and the counter starts from that value. A read returns the low byte of the count.
- R5: When access bits are 01 (high byte only), a data write loads {data, 0x00}. A read returns the high byte of the count.
- R6: When access bits are 11, the first data write gives the low byte and the second gives the high byte. Counting starts only after the second write. Successive reads return the low byte, then the high byte.
- R7: When access bits are 00 (latch), a data write has no effect on the reload value or the loaded flag. Successive reads return the low byte of the count, then the high byte.
- R8: A counter steps only on a tick, with its gate high, once loaded, and with mode bits 3:1 set to 010 or 011. Any other mode code holds the count. A low gate holds both the count and the output.
- R9: In rate generator mode (010), the tick that finds the count at 1 reloads the count and drives the output low until the next tick. The output is high at every other point.
- R10: In square wave mode (011), the tick that finds the count at 1 reloads the count and inverts the output.
- R11: After reset, every output is high, every count is zero, no counter is loaded, and the read data bus is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select for bus cycles |
| addr | input | 2 | Port offset |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| tick | input | 1 | Common count enable |
| gate | input | 3 | Per-counter gate |
| tout | output | 3 | Per-counter output |

## Verification
The assertions take for granted that the host never raises wr_en and rd_en in the same cycle. They also take for granted that a stable count or output is only promised when the bus is not touching that counter, meaning no write to its data port and no write to the control port. The bench keeps inside these limits. Every bus cycle is a single strobe driven on the falling edge. Gates and the tick change only between bus cycles. Each stretch of counting is preceded by a complete load, so the expected count and output can be worked out tick by tick.

// File: rtl/pit_pkg.sv
package pit_pkg;
   typedef enum logic [1:0] {
      ACC_LATCH = 2'b00,
      ACC_HI    = 2'b01,
      ACC_LO    = 2'b10,
      ACC_LOHI  = 2'b11
   } acc_e;

   typedef struct packed {
      acc_e       acc;
      logic [2:0] mode;
      logic       bcd;
   } ctl_t;

   localparam logic [2:0] MODE_RATE   = 3'd2;
   localparam logic [2:0] MODE_SQUARE = 3'd3;
   localparam logic [1:0] CTL_ADDR    = 2'b11;
endpackage

// File: rtl/pit_access.sv
module pit_access
   import pit_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int CNT_W = 2 * DATA_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  ctl_t              ctl_in,
   input  logic              dat_wr,
   input  logic              dat_rd,
   input  logic [DATA_W-1:0] wdata,
   input  logic [CNT_W-1:0]  count,
   output ctl_t              ctl_q,
   output logic              loaded,
   output logic              load_stb,
   output logic [CNT_W-1:0]  load_val,
   output logic [DATA_W-1:0] rd_byte
);
   logic              flip_q;
   logic [DATA_W-1:0] lo_hold_q;
   logic [DATA_W-1:0] cnt_lo, cnt_hi;

   assign cnt_lo = count[DATA_W-1:0];
   assign cnt_hi = count[CNT_W-1:DATA_W];

   always_comb begin
      case (ctl_q.acc)
         ACC_HI:  rd_byte = cnt_hi;
         ACC_LO:  rd_byte = cnt_lo;
         default: rd_byte = flip_q ? cnt_hi : cnt_lo;
      endcase
   end

   always_comb begin
      load_stb = 1'b0;
      load_val = '0;
      if (dat_wr) begin
         case (ctl_q.acc)
            ACC_HI: begin
               load_stb = 1'b1;
               load_val = {wdata, {DATA_W{1'b0}}};
            end
            ACC_LO: begin
               load_stb = 1'b1;
               load_val = {{DATA_W{1'b0}}, wdata};
            end
            ACC_LOHI: begin
               load_stb = flip_q;
               load_val = {wdata, lo_hold_q};
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q     <= '0;
         flip_q    <= 1'b0;
         loaded    <= 1'b0;
         lo_hold_q <= '0;
      end else if (ctl_wr) begin
         ctl_q  <= ctl_in;
         flip_q <= 1'b0;
         loaded <= 1'b0;
      end else begin
         if (load_stb)
            loaded <= 1'b1;
         if (dat_wr && ctl_q.acc == ACC_LOHI) begin
            flip_q <= ~flip_q;
            if (!flip_q)
               lo_hold_q <= wdata;
         end else if (dat_rd && (ctl_q.acc == ACC_LOHI || ctl_q.acc == ACC_LATCH)) begin
            flip_q <= ~flip_q;
         end
      end
   end
endmodule

// File: rtl/pit_counter.sv
module pit_counter
   import pit_pkg::*;
#(
   parameter int CNT_W = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             gate,
   input  logic             loaded,
   input  logic [2:0]       mode,
   input  logic             ctl_wr,
   input  logic             load_stb,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count,
   output logic             tout
);
   logic [CNT_W-1:0] reload_q;
   logic             run, at_end;

   assign run    = tick && gate && loaded && (mode == MODE_RATE || mode == MODE_SQUARE);
   assign at_end = (count == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count    <= '0;
         reload_q <= '0;
         tout     <= 1'b1;
      end else if (ctl_wr) begin
         tout <= 1'b1;
      end else if (load_stb) begin
         reload_q <= load_val;
         count    <= load_val;
      end else if (run) begin
         count <= at_end ? reload_q : count - CNT_W'(1);
         if (mode == MODE_RATE)
            tout <= !at_end;
         else if (at_end)
            tout <= ~tout;
      end
   end
endmodule

// File: rtl/pit3_timer.sv
module pit3_timer
   import pit_pkg::*;
#(
   parameter int NCHAN  = 3,
   parameter int DATA_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic [1:0]        addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              tick,
   input  logic [NCHAN-1:0]  gate,
   output logic [NCHAN-1:0]  tout
);
   localparam int CNT_W = 2 * DATA_W;

   if (NCHAN < 1 || NCHAN > 3) begin : g_bad_nchan
      $error("pit3_timer: NCHAN must be 1 to 3");
   end
   if (DATA_W < 8) begin : g_bad_width
      $error("pit3_timer: DATA_W must be at least 8");
   end

   logic                           bus_wr, bus_rd;
   logic [1:0]                     sel;
   ctl_t                           ctl_in;
   logic [NCHAN-1:0]               loaded_w;
   logic [NCHAN-1:0][2:0]          mode_w;
   logic [NCHAN-1:0][CNT_W-1:0]    count_w;
   logic [NCHAN-1:0][DATA_W-1:0]   rd_byte_w;
   logic [DATA_W-1:0]              rd_mux;

   assign bus_wr = cs && wr_en;
   assign bus_rd = cs && rd_en && !wr_en;
   assign sel    = wdata[7:6];
   assign ctl_in = ctl_t'(wdata[5:0]);

   for (genvar i = 0; i < NCHAN; i++) begin : g_chan
      logic              ctl_wr_i, dat_wr_i, dat_rd_i, load_stb_i;
      logic [CNT_W-1:0]  load_val_i;
      ctl_t              ctl_i;

      assign ctl_wr_i  = bus_wr && addr == CTL_ADDR && sel == 2'(i);
      assign dat_wr_i  = bus_wr && addr == 2'(i);
      assign dat_rd_i  = bus_rd && addr == 2'(i);
      assign mode_w[i] = ctl_i.mode;

      pit_access #(.DATA_W(DATA_W)) u_acc (
         .clk      (clk),
         .rst_n    (rst_n),
         .ctl_wr   (ctl_wr_i),
         .ctl_in   (ctl_in),
         .dat_wr   (dat_wr_i),
         .dat_rd   (dat_rd_i),
         .wdata    (wdata),
         .count    (count_w[i]),
         .ctl_q    (ctl_i),
         .loaded   (loaded_w[i]),
         .load_stb (load_stb_i),
         .load_val (load_val_i),
         .rd_byte  (rd_byte_w[i])
      );

      pit_counter #(.CNT_W(CNT_W)) u_cnt (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick     (tick),
         .gate     (gate[i]),
         .loaded   (loaded_w[i]),
         .mode     (ctl_i.mode),
         .ctl_wr   (ctl_wr_i),
         .load_stb (load_stb_i),
         .load_val (load_val_i),
         .count    (count_w[i]),
         .tout     (tout[i])
      );
   end

   always_comb begin
      rd_mux = '1;
      for (int i = 0; i < NCHAN; i++)
         if (addr == 2'(i))
            rd_mux = rd_byte_w[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (bus_rd)
         rdata <= rd_mux;
   end
endmodule

// File: rtl/pit3_timer_chk.sv
module pit3_timer_chk #(
   parameter int NCHAN  = 3,
   parameter int DATA_W = 8,
   localparam int CNT_W = 2 * DATA_W
)(
   input logic                         clk,
   input logic                         rst_n,
   input logic                         cs,
   input logic [1:0]                   addr,
   input logic                         wr_en,
   input logic                         rd_en,
   input logic [DATA_W-1:0]            rdata,
   input logic                         tick,
   input logic [NCHAN-1:0]             gate,
   input logic [NCHAN-1:0]             tout,
   input logic [NCHAN-1:0]             loaded_w,
   input logic [NCHAN-1:0][2:0]        mode_w,
   input logic [NCHAN-1:0][CNT_W-1:0]  count_w
);
   AST_CTRL_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && rd_en && !wr_en && addr == 2'b11) |=> (rdata == '1)); // R1

   for (genvar i = 0; i < NCHAN; i++) begin : g_chk
      logic touch;
      logic steps;
      assign touch = cs && wr_en && (addr == 2'(i) || addr == 2'b11);
      assign steps = tick && gate[i] && loaded_w[i] && !touch;

      AST_GATE_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         (!gate[i] && !touch) |=> ($stable(count_w[i]) && $stable(tout[i]))); // R8

      AST_IDLE_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_w[i] != 3'd2 && mode_w[i] != 3'd3 && !touch) |=> $stable(count_w[i])); // R8

      AST_RATE_PULSE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         (steps && mode_w[i] == 3'd2 && count_w[i] == CNT_W'(1)) |=> !tout[i]); // R9

      AST_RATE_HIGH_ELSE: assert property (@(posedge clk) disable iff (!rst_n)
         (steps && mode_w[i] == 3'd2 && count_w[i] != CNT_W'(1)) |=> tout[i]); // R9

      AST_SQUARE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
         (steps && mode_w[i] == 3'd3 && count_w[i] == CNT_W'(1)) |=> (tout[i] != $past(tout[i]))); // R10
   end
endmodule

bind pit3_timer pit3_timer_chk #(.NCHAN(NCHAN), .DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs       (cs),
   .addr     (addr),
   .wr_en    (wr_en),
   .rd_en    (rd_en),
   .rdata    (rdata),
   .tick     (tick),
   .gate     (gate),
   .tout     (tout),
   .loaded_w (loaded_w),
   .mode_w   (mode_w),
   .count_w  (count_w)
);

// File: tb/pit3_timer_test.sv
module pit3_timer_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs = 1'b0;
   logic [1:0] addr = '0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       tick = 1'b0;
   logic [2:0] gate = '0;
   logic [2:0] tout;

   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #5 clk = ~clk;

   pit3_timer uut (
      .clk   (clk),
      .rst_n (rst_n),
      .cs    (cs),
      .addr  (addr),
      .wr_en (wr_en),
      .rd_en (rd_en),
      .wdata (wdata),
      .rdata (rdata),
      .tick  (tick),
      .gate  (gate),
      .tout  (tout)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      cs = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      cs = 1'b0; wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      cs = 1'b1; rd_en = 1'b1; addr = a;
      @(negedge clk);
      cs = 1'b0; rd_en = 1'b0;
   endtask

   task automatic pulse_tick();
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   // scoreboard monitor: pops one expected byte per read strobe
   initial begin
      forever begin
         @(posedge clk);
         if (cs && rd_en) begin
            @(negedge clk);
            if (exp_q.size() == 0) begin
               checks++; errors++;
               $display("FAIL scoreboard underflow actual=%h expected=none", rdata);
            end else begin
               check(tag_q.pop_front(), {8'h00, rdata}, {8'h00, exp_q.pop_front()});
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 outputs high", {13'd0, tout}, 16'h0007);
      check("R11 rdata zero", {8'h00, rdata}, 16'h0000);
      bus_rd(2'd0, 8'h00, "R11 count0 low");
      bus_rd(2'd0, 8'h00, "R11 count0 high");

      bus_rd(2'd3, 8'hFF, "R1 control port read");

      // counter 1: low-only, rate mode
      bus_wr(2'd3, 8'h64);
      bus_wr(2'd1, 8'h05);
      bus_rd(2'd1, 8'h05, "R4 low-only read");
      bus_rd(2'd1, 8'h05, "R4 low-only read repeat");

      // counter 2: high-only, square mode
      bus_wr(2'd3, 8'h96);
      bus_wr(2'd2, 8'h02);
      bus_rd(2'd2, 8'h02, "R5 high-only read");

      // counter 0: low-then-high, rate mode, reload 2
      bus_wr(2'd3, 8'h34);
      bus_wr(2'd0, 8'h02);
      bus_wr(2'd0, 8'h00);
      bus_wr(2'd3, 8'h34);
      gate = 3'b001;
      pulse_tick(); pulse_tick(); pulse_tick();
      bus_rd(2'd0, 8'h02, "R3 unloaded holds low");
      bus_rd(2'd0, 8'h00, "R3 unloaded holds high");

      // R3: toggle cleared by control write
      bus_wr(2'd0, 8'h05);
      bus_wr(2'd3, 8'h34);
      bus_wr(2'd0, 8'h06);
      bus_wr(2'd0, 8'h00);
      bus_rd(2'd0, 8'h06, "R3 toggle cleared low");
      bus_rd(2'd0, 8'h00, "R3 toggle cleared high");

      // R6: no counting after only the first byte
      bus_wr(2'd3, 8'h34);
      bus_wr(2'd0, 8'h03);
      pulse_tick();
      pulse_tick();
      check("R6 no count before high byte", {15'd0, tout[0]}, 16'd1);
      bus_wr(2'd0, 8'h00);

      // R9: rate generator with reload 3
      pulse_tick(); check("R9 tick1 out", {15'd0, tout[0]}, 16'd1);
      pulse_tick(); check("R9 tick2 out", {15'd0, tout[0]}, 16'd1);
      pulse_tick(); check("R9 tick3 pulse low", {15'd0, tout[0]}, 16'd0);
      pulse_tick(); check("R9 tick4 out high", {15'd0, tout[0]}, 16'd1);
      bus_rd(2'd0, 8'h02, "R9 count low");
      bus_rd(2'd0, 8'h00, "R6 alternate high");

      // R8: gate low holds
      gate = 3'b000;
      pulse_tick(); pulse_tick(); pulse_tick();
      bus_rd(2'd0, 8'h02, "R8 gate low holds");
      bus_rd(2'd0, 8'h00, "R8 gate low holds high");

      // R8: idle mode holds
      bus_wr(2'd3, 8'h60);
      bus_wr(2'd1, 8'h07);
      gate = 3'b010;
      pulse_tick(); pulse_tick(); pulse_tick();
      bus_rd(2'd1, 8'h07, "R8 mode0 holds");

      // R10: square wave, reload 2
      gate = 3'b000;
      bus_wr(2'd3, 8'hA6);
      bus_wr(2'd2, 8'h02);
      gate = 3'b100;
      pulse_tick(); check("R10 tick1", {15'd0, tout[2]}, 16'd1);
      pulse_tick(); check("R10 tick2 flip", {15'd0, tout[2]}, 16'd0);
      pulse_tick(); check("R10 tick3", {15'd0, tout[2]}, 16'd0);
      pulse_tick(); check("R10 tick4 flip", {15'd0, tout[2]}, 16'd1);
      gate = 3'b000;

      // R2: select code 11 ignored
      bus_wr(2'd3, 8'hF4);
      bus_rd(2'd2, 8'h02, "R2 ch2 unchanged");
      bus_rd(2'd2, 8'h02, "R2 ch2 still low-only");
      bus_rd(2'd1, 8'h07, "R2 ch1 unchanged");
      bus_rd(2'd1, 8'h07, "R2 ch1 still low-only");
      check("R2 outputs", {13'd0, tout}, 16'h0007);

      // R7: latch-mode write ignored
      bus_wr(2'd3, 8'h44);
      bus_wr(2'd1, 8'h09);
      gate = 3'b010;
      pulse_tick(); pulse_tick();
      bus_rd(2'd1, 8'h07, "R7 latch read low");
      bus_rd(2'd1, 8'h00, "R7 latch read high");
      gate = 3'b000;

      repeat (4) @(negedge clk);
      check("scoreboard drained", 16'(exp_q.size()), 16'd0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule